// File: doc/BRIEF.md
# First-Fit Page Allocator for Shared Queue Memory

The block keeps track of which pages of a shared queue memory are in use. The memory holds 128 pages of 16 dwords each. The lowest four pages hold configuration words, so they are marked used from reset onward and can never be handed out or released. A client asks for a run of 1, 2, 4 or 8 consecutive pages. The allocator then looks for the lowest start page at which the whole run is free and marks that run used. It reports the start page, or it reports that no room is left.

A client can also hand back a run by giving its start page and its length code. The allocator then clears exactly those pages. Both kinds of request share one valid/busy handshake. An allocation scans candidate start pages one per clock and may take many cycles, and `busy_o` stays high for the whole scan. A release finishes in one cycle. Each request ends with a one-cycle `done_o` pulse, and `ok_o` shows whether the request took effect.

Top module: `page_alloc`

## Requirements
- R1: After reset `busy_o` and `done_o` are low, pages 0 to 3 are used and every other page is free. Pages 0 to 3 remain used at all times.
- R2: The length code `req_len_i` selects the run length in pages: 0 gives 1 page, 1 gives 2, 2 gives 4 and 3 gives 8. A successful allocation marks exactly that many pages used.
- R3: An allocation grants the lowest start page whose whole run is free. Start pages are tried in steps of one page, so a granted start need not be a multiple of the run length.
- R4: An allocation is accepted on a rising edge with `req_valid_i` high, `req_free_i` low and `busy_o` low. It checks one candidate start per cycle, beginning at page 0. On success at start page p, `done_o` and `ok_o` are high, and `page_o` equals p, in the cycle after the (p+1)-th rising edge that follows the accepting edge. `busy_o` is high from the accepting edge until that edge.
- R5: When no run fits, the allocation fails. Once the candidate start plus the run length exceeds 128, `done_o` pulses with `ok_o` low, and no page changes state. For a run of L pages this happens on the (130 - L)-th edge after acceptance.
- R6: A release (`req_free_i` high) clears exactly the pages from `req_page_i` to `req_page_i` plus the run length minus one. All other pages keep their state.
- R7: A release that includes a page below 4, or that would extend past page 127, is ignored. It still ends with a `done_o` pulse, with `ok_o` low.
- R8: While `busy_o` is high, `req_valid_i` is ignored. A release presented during a search has no effect.
- R9: A release is accepted only while `busy_o` is low. It is completed on the accepting edge, so `done_o` is high in the cycle right after that edge, with `ok_o` high when the release is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_free_i | input | 1 | 1 = release a run, 0 = allocate a run |
| req_len_i | input | 2 | Run length code (0..3 = 1, 2, 4, 8 pages) |
| req_page_i | input | 7 | Start page of a release |
| busy_o | output | 1 | Allocation search in progress |
| done_o | output | 1 | One-cycle pulse at the end of each request |
| ok_o | output | 1 | Request took effect (valid with done_o) |
| page_o | output | 7 | Granted start page (valid with done_o and ok_o) |

## Verification
The bench runs allocations against several occupancy patterns:

- **Empty memory.** The first grant lands at page 4 right after the reserved pages. This separates a correct reset image from one that reserves too few or too many pages.
- **A one-page hole below a used page.** A two-page request must skip the hole and land at an unaligned start. This distinguishes a one-page step from an aligned step.
- **Gaps that fit only the shorter lengths.** These show that the hole found is the lowest one, and that a release cleared neither more nor fewer pages than its run.
- **A nearly full memory.** Runs of 8, 2 and 1 pages probe the upper end of the page range, where the bound check decides between a grant at page 126 and a failure.

In each case the cycle count to `done_o` identifies the candidate at which the search stopped. A release presented during a long search, and releases aimed at reserved or out-of-range pages, are followed by allocations whose results would change if those releases had been applied.

// File: rtl/page_alloc_pkg.sv
package page_alloc_pkg;
  localparam int unsigned LEN_CODE_W = 2;

  typedef enum logic {
    ST_IDLE,
    ST_SEARCH
  } alloc_state_e;
endpackage

// File: rtl/page_run_mask.sv
module page_run_mask #(
  parameter int unsigned NUM_PAGES = 128,
  parameter int unsigned START_W   = 8,
  parameter int unsigned LEN_W     = 2
) (
  input  logic [START_W-1:0]   start_i,
  input  logic [LEN_W-1:0]     len_i,
  output logic [NUM_PAGES-1:0] mask_o
);
  localparam int unsigned END_W = START_W + (1 << LEN_W);

  logic [END_W-1:0] first_w;
  logic [END_W-1:0] last_x_w;  // one past the last page of the run

  assign first_w  = END_W'(start_i);
  assign last_x_w = first_w + (END_W'(1) << len_i);

  for (genvar i = 0; i < NUM_PAGES; i++) begin : g_bit
    assign mask_o[i] = (END_W'(i) >= first_w) && (END_W'(i) < last_x_w);
  end
endmodule

// File: rtl/page_bitmap.sv
module page_bitmap #(
  parameter int unsigned NUM_PAGES  = 128,
  parameter int unsigned RSVD_PAGES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 set_en_i,
  input  logic                 clr_en_i,
  input  logic [NUM_PAGES-1:0] mask_i,
  output logic [NUM_PAGES-1:0] used_o
);
  localparam logic [NUM_PAGES-1:0] RSVD_MASK =
    {NUM_PAGES{1'b1}} >> (NUM_PAGES - RSVD_PAGES);

  logic [NUM_PAGES-1:0] used_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      used_q <= RSVD_MASK;
    end else if (set_en_i) begin
      used_q <= used_q | mask_i;
    end else if (clr_en_i) begin
      used_q <= (used_q & ~mask_i) | RSVD_MASK;
    end
  end

  assign used_o = used_q;
endmodule

// File: rtl/page_alloc_ctrl.sv
module page_alloc_ctrl
  import page_alloc_pkg::*;
#(
  parameter int unsigned NUM_PAGES  = 128,
  parameter int unsigned RSVD_PAGES = 4,
  parameter int unsigned PAGE_W     = 7,
  parameter int unsigned LEN_W      = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic                 req_free_i,
  input  logic [LEN_W-1:0]     req_len_i,
  input  logic [PAGE_W-1:0]    req_page_i,
  input  logic [NUM_PAGES-1:0] used_i,
  input  logic [NUM_PAGES-1:0] win_mask_i,
  output logic [PAGE_W:0]      win_start_o,
  output logic [LEN_W-1:0]     win_len_o,
  output logic                 set_en_o,
  output logic                 clr_en_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 ok_o,
  output logic [PAGE_W-1:0]    page_o
);
  localparam int unsigned END_W = PAGE_W + 1 + (1 << LEN_W);

  alloc_state_e      state_q;
  logic [PAGE_W:0]   cand_q;   // one bit wider: a 1-page scan reaches NUM_PAGES
  logic [LEN_W-1:0]  len_q;
  logic              done_q, ok_q;
  logic [PAGE_W-1:0] page_q;

  logic             busy_w, accept_w, over_w, clash_w, free_go_w;
  logic [END_W-1:0] win_end_w;

  assign busy_w      = (state_q == ST_SEARCH);
  assign accept_w    = req_valid_i && !busy_w;
  assign win_start_o = busy_w ? cand_q : {1'b0, req_page_i};
  assign win_len_o   = busy_w ? len_q : req_len_i;
  assign win_end_w   = END_W'(win_start_o) + (END_W'(1) << win_len_o);
  assign over_w      = win_end_w > END_W'(NUM_PAGES);
  assign clash_w     = |(used_i & win_mask_i);
  assign free_go_w   = accept_w && req_free_i && !over_w &&
                       (END_W'(win_start_o) >= END_W'(RSVD_PAGES));

  assign set_en_o = busy_w && !over_w && !clash_w;
  assign clr_en_o = free_go_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cand_q  <= '0;
      len_q   <= '0;
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
      page_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept_w) begin
            if (req_free_i) begin
              done_q <= 1'b1;
              ok_q   <= free_go_w;
            end else begin
              state_q <= ST_SEARCH;
              cand_q  <= '0;
              len_q   <= req_len_i;
            end
          end
        end
        ST_SEARCH: begin
          if (over_w) begin
            done_q  <= 1'b1;
            ok_q    <= 1'b0;
            state_q <= ST_IDLE;
          end else if (!clash_w) begin
            done_q  <= 1'b1;
            ok_q    <= 1'b1;
            page_q  <= cand_q[PAGE_W-1:0];
            state_q <= ST_IDLE;
          end else begin
            cand_q <= cand_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = busy_w;
  assign done_o = done_q;
  assign ok_o   = ok_q;
  assign page_o = page_q;
endmodule

// File: rtl/page_alloc.sv
module page_alloc
  import page_alloc_pkg::*;
#(
  parameter int unsigned NUM_PAGES  = 128,
  parameter int unsigned RSVD_PAGES = 4,
  parameter int unsigned LEN_W      = LEN_CODE_W,
  localparam int unsigned PAGE_W    = $clog2(NUM_PAGES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_free_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic [PAGE_W-1:0] req_page_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              ok_o,
  output logic [PAGE_W-1:0] page_o
);
  logic [NUM_PAGES-1:0] used_w;
  logic [NUM_PAGES-1:0] win_mask_w;
  logic [PAGE_W:0]      win_start_w;
  logic [LEN_W-1:0]     win_len_w;
  logic                 set_en_w, clr_en_w;

  page_run_mask #(
    .NUM_PAGES(NUM_PAGES),
    .START_W  (PAGE_W + 1),
    .LEN_W    (LEN_W)
  ) u_mask (
    .start_i(win_start_w),
    .len_i  (win_len_w),
    .mask_o (win_mask_w)
  );

  page_bitmap #(
    .NUM_PAGES (NUM_PAGES),
    .RSVD_PAGES(RSVD_PAGES)
  ) u_bitmap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_en_i(set_en_w),
    .clr_en_i(clr_en_w),
    .mask_i  (win_mask_w),
    .used_o  (used_w)
  );

  page_alloc_ctrl #(
    .NUM_PAGES (NUM_PAGES),
    .RSVD_PAGES(RSVD_PAGES),
    .PAGE_W    (PAGE_W),
    .LEN_W     (LEN_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_free_i (req_free_i),
    .req_len_i  (req_len_i),
    .req_page_i (req_page_i),
    .used_i     (used_w),
    .win_mask_i (win_mask_w),
    .win_start_o(win_start_w),
    .win_len_o  (win_len_w),
    .set_en_o   (set_en_w),
    .clr_en_o   (clr_en_w),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .ok_o       (ok_o),
    .page_o     (page_o)
  );
endmodule

// File: rtl/page_alloc_chk.sv
module page_alloc_chk #(
  parameter int unsigned NUM_PAGES  = 128,
  parameter int unsigned RSVD_PAGES = 4,
  parameter int unsigned LEN_W      = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 busy_i,
  input logic                 done_i,
  input logic                 ok_i,
  input logic [NUM_PAGES-1:0] used_i,
  input logic [LEN_W-1:0]     len_i
);
  // R1
  reserved_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used_i[RSVD_PAGES-1:0] == {RSVD_PAGES{1'b1}});

  // R2
  grant_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && ok_i && $past(busy_i) |->
      $countones(used_i) == $countones($past(used_i)) + (32'd1 << $past(len_i)));

  // R4
  search_ends_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> done_i);

  // R5
  fail_no_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !ok_i |-> $stable(used_i));

  // R6
  free_no_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && ok_i && !$past(busy_i) |->
      $countones(used_i) <= $countones($past(used_i)));

  // R8
  busy_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> $stable(used_i));
endmodule

bind page_alloc page_alloc_chk #(
  .NUM_PAGES (NUM_PAGES),
  .RSVD_PAGES(RSVD_PAGES),
  .LEN_W     (LEN_W)
) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .busy_i(busy_o),
  .done_i(done_o),
  .ok_i  (ok_o),
  .used_i(used_w),
  .len_i (win_len_w)
);

// File: tb/page_alloc_bench.sv
module page_alloc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NPAGES = 128;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_free = 1'b0;
  logic [1:0] req_len = '0;
  logic [6:0] req_page = '0;
  logic       busy, done, ok;
  logic [6:0] page;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  page_alloc u_page_alloc (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .req_valid_i(req_valid),
    .req_free_i (req_free),
    .req_len_i  (req_len),
    .req_page_i (req_page),
    .busy_o     (busy),
    .done_o     (done),
    .ok_o       (ok),
    .page_o     (page)
  );

  task automatic check(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Allocate; optionally present a release of pages 14..21 during the first 5 search cycles.
  task automatic do_alloc(input logic [1:0] len, input bit exp_ok, input int exp_page,
                          input int exp_lat, input bit intrude, input string tag);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_free = 1'b0; req_len = len;
    @(posedge clk); #1;
    check(busy == 1'b1, {tag, " busy after accept (R4)"}, busy, 1);
    n = 0;
    while (n < 400) begin
      @(negedge clk);
      req_valid = intrude && (n < 5);
      req_free  = 1'b1; req_page = 7'd14; req_len = 2'd3;
      @(posedge clk); #1;
      n++;
      if (done) break;
    end
    @(negedge clk);
    req_valid = 1'b0; req_free = 1'b0;
    check(n == exp_lat, {tag, " latency"}, n, exp_lat);
    check(ok == exp_ok, {tag, " ok"}, ok, exp_ok);
    if (exp_ok) check(page == 7'(exp_page), {tag, " page"}, page, exp_page);
  endtask

  task automatic do_free(input int start, input logic [1:0] len, input bit exp_ok,
                         input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_free = 1'b1; req_len = len; req_page = 7'(start);
    @(posedge clk); #1;
    check(done == 1'b1, {tag, " done next cycle (R9)"}, done, 1);
    check(ok == exp_ok, {tag, " ok"}, ok, exp_ok);
    @(negedge clk);
    req_valid = 1'b0; req_free = 1'b0;
  endtask

  task automatic test_reset();
    #1;
    check(busy == 1'b0, "R1 busy in reset", busy, 0);
    check(done == 1'b0, "R1 done in reset", done, 0);
    // first grant right after reserved pages
    do_alloc(2'd0, 1'b1, 4, 5, 1'b0, "R1 R2 R4 first page");
  endtask

  task automatic test_first_fit();
    do_alloc(2'd1, 1'b1, 5, 6, 1'b0, "R2 two pages");
    do_free(4, 2'd0, 1'b1, "R9 free page 4");
    do_alloc(2'd1, 1'b1, 7, 8, 1'b0, "R3 unaligned start");
    do_alloc(2'd0, 1'b1, 4, 5, 1'b0, "R3 lowest hole");
  endtask

  task automatic test_ignored_free();
    do_free(2, 2'd0, 1'b0, "R7 reserved page");
    do_free(126, 2'd2, 1'b0, "R7 past end");
    // pages 0..8 used; page 2 must still be used
    do_alloc(2'd0, 1'b1, 9, 10, 1'b0, "R7 reserved kept");
  endtask

  task automatic test_exact_free();
    do_free(5, 2'd1, 1'b1, "R6 free 5..6");
    do_alloc(2'd2, 1'b1, 10, 11, 1'b0, "R6 neighbour 7 kept");
    do_alloc(2'd1, 1'b1, 5, 6, 1'b0, "R6 freed pair reused");
  endtask

  task automatic test_fill();
    for (int k = 0; k < 14; k++) begin
      do_alloc(2'd3, 1'b1, 14 + 8 * k, 15 + 8 * k, 1'b0, "R2 R3 fill eight");
    end
    // busy search: release presented mid-search must be dropped
    do_alloc(2'd3, 1'b0, 0, NPAGES - 8 + 2, 1'b1, "R5 R8 no room for eight");
    do_alloc(2'd1, 1'b1, 126, 127, 1'b0, "R3 top pair");
    do_alloc(2'd0, 1'b0, 0, NPAGES - 1 + 2, 1'b0, "R5 full");
    do_free(14, 2'd3, 1'b1, "R6 free 14..21");
    do_alloc(2'd2, 1'b1, 14, 15, 1'b0, "R6 R8 reuse freed run");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_first_fit();
    test_ignored_free();
    test_exact_free();
    test_fill();
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule